// File: doc/BRIEF.md
# Packed SIMD Compare and Arithmetic Unit

This block runs one lane-parallel operation over two 64-bit operands. The operands are cut into 8-bit, 16-bit or 32-bit lanes, chosen per request by a lane-size code. Every lane gets the same operation. The operations are:

- equality, signed and unsigned greater-than compares
- signed and unsigned minimum and maximum
- wrap-around add and subtract
- saturating add and subtract, signed and unsigned
- an average with an optional round-up bit

Each result comes with a 32-bit status word. It holds a negative bit and a zero bit for every result lane, and the positions of those bits follow the lane width.

The caller presents both operands, a lane-size code and an operation code, and asserts `in_valid` for one cycle. On the next cycle the unit presents the result and the status word together, marked by a one-cycle `out_valid` pulse. Both outputs keep their values until the next accepted request. The unit has no back-pressure and can take a new request on every cycle.

Top module: `pack_simd_alu`

## Requirements
- R1: Operation codes 0, 1 and 2 are the compares: equal, signed greater-than and unsigned greater-than. Each result lane is all ones when the condition holds and all zeros otherwise.
- R2: Operation codes 3, 4, 5 and 6 are signed minimum, unsigned minimum, signed maximum and unsigned maximum. Each result lane is an exact copy of the winning operand's lane.
- R3: Operation code 7 is add and code 8 is subtract (a minus b). Both keep only the low lane-width bits of each lane, so the result wraps.
- R4: Operation codes 9 and 10 are unsigned saturating add and subtract. Codes 11 and 12 are signed saturating add and subtract. A lane that would overflow is clamped to the bound of the lane's range.
- R5: Operation code 13 gives (a+b)>>1 per lane. Code 14 gives (a+b+1)>>1 per lane. The sum is formed one bit wider than the lane, so no carry is lost.
- R6: Lane-size code 0 selects eight 8-bit lanes and code 1 selects four 16-bit lanes. Codes 2 and 3 both select two 32-bit lanes. Lane i always occupies operand bits i*W .. i*W+W-1.
- R7: For lane width W, status bit (W/2)*i + W/2 - 1 is lane i's most significant result bit (N). Status bit (W/2)*i + W/2 - 2 is set when lane i is all zeros (Z). Every other status bit is zero. For 8-bit lanes this gives bits 4i+3 = N, 4i+2 = Z, 4i+1 = carry (0) and 4i = overflow (0).
- R8: For the average codes 13 and 14, every N bit is zero and only the Z bits report the result.
- R9: `out_valid` goes high in the cycle after `in_valid` is sampled high and is low otherwise. Result and status word update in that same cycle.
- R10: While `in_valid` is low, result and status word hold their values. Synchronous active-low reset clears result, status word and `out_valid` to zero.
- R11: Operation code 15 is reserved. It gives a zero result, so each lane reports Z set and N clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request qualifier |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| lane_sz | input | 2 | Lane-size code |
| op_sel | input | 4 | Operation code |
| out_valid | output | 1 | One-cycle pulse marking a fresh result |
| result | output | 64 | Registered packed result |
| flags | output | 32 | Registered per-lane status word |

## Verification
The hardest lanes to reach are the saturating ones at the edge of the range, where the clamp takes over from the wrapped sum. Uniform random operands hit them rarely. A directed set forces each overflow direction for every lane width: maximum positive plus one, minimum negative minus one, all-ones plus one, and zero minus one. Random operands are also biased toward lane values near 0, 0x7F.. and 0x80.., and toward equal lanes, which covers the compare-equal and the zero-flag cases. A hold check after every request changes the operands while `in_valid` is low, then confirms that nothing on the outputs moved.

// File: rtl/psa_pkg.sv
// Shared operation encoding for the packed SIMD compare/arithmetic unit.
// Assumes a 4-bit operation field; code 15 is reserved.
package psa_pkg;
    typedef enum logic [3:0] {
        OP_CMPEQ  = 4'd0,
        OP_CMPGTS = 4'd1,
        OP_CMPGTU = 4'd2,
        OP_MINS   = 4'd3,
        OP_MINU   = 4'd4,
        OP_MAXS   = 4'd5,
        OP_MAXU   = 4'd6,
        OP_ADD    = 4'd7,
        OP_SUB    = 4'd8,
        OP_ADDUS  = 4'd9,
        OP_SUBUS  = 4'd10,
        OP_ADDSS  = 4'd11,
        OP_SUBSS  = 4'd12,
        OP_AVG    = 4'd13,
        OP_AVGR   = 4'd14,
        OP_RSVD   = 4'd15
    } psa_op_e;
endpackage

// File: rtl/psa_lane.sv
// One lane of width W: computes every operation on a W-bit lane pair and
// returns the one selected by op. Purely combinational; assumes W >= 2.
module psa_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  psa_pkg::psa_op_e op,
    output logic [W-1:0]     res
);
    import psa_pkg::*;

    localparam logic [W-1:0] ONES    = {W{1'b1}};
    localparam logic [W-1:0] SMAX    = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN    = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   sum_x;
    logic [W:0]   dif_x;
    logic [W:0]   avg_x;
    logic         gt_s, gt_u, eq_ab;
    logic         ovf_add_s, ovf_sub_s;

    // Widened sum, difference and average, plus compare terms.
    always_comb begin
        sum_x     = {1'b0, a} + {1'b0, b};
        dif_x     = {1'b0, a} - {1'b0, b};
        avg_x     = sum_x + {{W{1'b0}}, (op == OP_AVGR)};
        gt_s      = $signed(a) > $signed(b);
        gt_u      = a > b;
        eq_ab     = a == b;
        ovf_add_s = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
        ovf_sub_s = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
    end

    // Select the lane result for the requested operation.
    always_comb begin
        unique case (op)
            OP_CMPEQ:  res = eq_ab ? ONES : '0;
            OP_CMPGTS: res = gt_s  ? ONES : '0;
            OP_CMPGTU: res = gt_u  ? ONES : '0;
            OP_MINS:   res = gt_s  ? b : a;
            OP_MINU:   res = gt_u  ? b : a;
            OP_MAXS:   res = gt_s  ? a : b;
            OP_MAXU:   res = gt_u  ? a : b;
            OP_ADD:    res = sum_x[W-1:0];
            OP_SUB:    res = dif_x[W-1:0];
            OP_ADDUS:  res = sum_x[W] ? ONES : sum_x[W-1:0];
            OP_SUBUS:  res = dif_x[W] ? '0   : dif_x[W-1:0];
            OP_ADDSS:  res = ovf_add_s ? (a[W-1] ? SMIN : SMAX) : sum_x[W-1:0];
            OP_SUBSS:  res = ovf_sub_s ? (a[W-1] ? SMIN : SMAX) : dif_x[W-1:0];
            OP_AVG,
            OP_AVGR:   res = avg_x[W:1];
            default:   res = '0;
        endcase
    end
endmodule

// File: rtl/psa_flag_pack.sv
// Packs N and Z for every lane of width LW into a DATA_W/2 status word.
// Lane i owns LW/2 status bits; N is the top one, Z the next, rest zero.
// Assumes LW >= 4 and DATA_W a multiple of LW.
module psa_flag_pack #(
    parameter int DATA_W = 64,
    parameter int LW     = 8
) (
    input  logic [DATA_W-1:0]   res,
    input  logic                z_only,
    output logic [DATA_W/2-1:0] flags
);
    localparam int NL   = DATA_W / LW;
    localparam int SLOT = LW / 2;

    // Build the status word lane by lane.
    always_comb begin
        flags = '0;
        for (int k = 0; k < NL; k++) begin
            flags[k*SLOT + SLOT - 1] = z_only ? 1'b0 : res[k*LW + LW - 1];
            flags[k*SLOT + SLOT - 2] = (res[k*LW +: LW] == '0);
        end
    end
endmodule

// File: rtl/pack_simd_alu.sv
// Packed SIMD compare/arithmetic unit. Builds every lane width in parallel,
// picks the one named by lane_sz, and registers result and status together
// with a one-cycle out_valid pulse. Assumes DATA_W is a multiple of 32.
module pack_simd_alu #(
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    input  logic [1:0]          lane_sz,
    input  logic [3:0]          op_sel,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic [DATA_W/2-1:0] flags
);
    import psa_pkg::*;

    localparam int NWID   = 3;
    localparam int FLAG_W = DATA_W / 2;

    psa_op_e           op;
    logic              z_only;
    logic [1:0]        wsel;
    logic [DATA_W-1:0] res_w [NWID];
    logic [FLAG_W-1:0] flg_w [NWID];

    // Decode operation and lane-width selector.
    always_comb begin
        op     = psa_op_e'(op_sel);
        z_only = (op == OP_AVG) || (op == OP_AVGR);
        wsel   = (lane_sz == 2'd0) ? 2'd0 : (lane_sz == 2'd1) ? 2'd1 : 2'd2;
    end

    for (genvar g = 0; g < NWID; g++) begin : g_wid
        localparam int LW = 8 << g;
        localparam int NL = DATA_W / LW;
        logic [DATA_W-1:0] lane_res;
        for (genvar k = 0; k < NL; k++) begin : g_lane
            psa_lane #(.W(LW)) u_lane (
                .a   (opnd_a[k*LW +: LW]),
                .b   (opnd_b[k*LW +: LW]),
                .op  (op),
                .res (lane_res[k*LW +: LW])
            );
        end
        psa_flag_pack #(.DATA_W(DATA_W), .LW(LW)) u_flg (
            .res    (lane_res),
            .z_only (z_only),
            .flags  (flg_w[g])
        );
        assign res_w[g] = lane_res;
    end

    // Register the chosen width's result, status and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_w[wsel];
                flags  <= flg_w[wsel];
            end
        end
    end
endmodule

// File: rtl/pack_simd_alu_chk.sv
// Property checker for pack_simd_alu, attached by bind below.
// Observes ports only; expectations derive from the requirement text.
module pack_simd_alu_chk #(
    parameter int DATA_W = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [1:0]          lane_sz,
    input logic [3:0]          op_sel,
    input logic                out_valid,
    input logic [DATA_W-1:0]   result,
    input logic [DATA_W/2-1:0] flags
);
    function automatic int lw_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    endfunction

    function automatic logic [DATA_W/2-1:0] nz_expect(
        input logic [DATA_W-1:0] r, input logic [1:0] sz, input logic [3:0] o);
        logic [DATA_W/2-1:0] f;
        logic [DATA_W-1:0]   m;
        int w;
        w = lw_of(sz);
        m = (DATA_W'(1) << w) - 1;
        f = '0;
        for (int k = 0; k < DATA_W/8; k++) begin
            if (k*w < DATA_W) begin
                if (o != 4'd13 && o != 4'd14)
                    f[k*(w/2) + w/2 - 1] = r[k*w + w - 1];
                f[k*(w/2) + w/2 - 2] = (((r >> (k*w)) & m) == '0);
            end
        end
        return f;
    endfunction

    function automatic logic lanes_solid(input logic [DATA_W-1:0] r, input logic [1:0] sz);
        logic [DATA_W-1:0] m, v;
        logic ok;
        int w;
        w  = lw_of(sz);
        m  = (DATA_W'(1) << w) - 1;
        ok = 1'b1;
        for (int k = 0; k < DATA_W/8; k++) begin
            if (k*w < DATA_W) begin
                v = (r >> (k*w)) & m;
                if (v != '0 && v != m) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flags)));
    // R7
    flag_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (flags == nz_expect(result, $past(lane_sz), $past(op_sel))));
    // R1
    cmp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel <= 4'd2) |=> lanes_solid(result, $past(lane_sz)));
endmodule

bind pack_simd_alu pack_simd_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .lane_sz   (lane_sz),
    .op_sel    (op_sel),
    .out_valid (out_valid),
    .result    (result),
    .flags     (flags)
);

// File: tb/test_pack_simd_alu.sv
`timescale 1ns/1ps
module test_pack_simd_alu;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] opnd_a = '0;
    logic [DW-1:0] opnd_b = '0;
    logic [1:0]    lane_sz = '0;
    logic [3:0]    op_sel = '0;
    logic          out_valid;
    logic [DW-1:0] result;
    logic [31:0]   flags;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pack_simd_alu #(.DATA_W(DW)) i_pack_simd_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .lane_sz(lane_sz), .op_sel(op_sel),
        .out_valid(out_valid), .result(result), .flags(flags)
    );

    function automatic int wid(input logic [1:0] sz);
        return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    endfunction

    // Reference per-lane result from the requirements (R1-style codes listed in BRIEF).
    function automatic logic [63:0] ref_res(input logic [63:0] a, input logic [63:0] b,
                                            input logic [1:0] sz, input logic [3:0] op);
        logic [63:0] out;
        longint mask, half, ua, ub, sa, sb, r, s;
        int w;
        w    = wid(sz);
        mask = (longint'(1) << w) - 1;
        half = longint'(1) << (w - 1);
        out  = '0;
        for (int k = 0; k < 64 / w; k++) begin
            ua = longint'((a >> (k*w))) & mask;
            ub = longint'((b >> (k*w))) & mask;
            sa = (ua >= half) ? ua - 2*half : ua;
            sb = (ub >= half) ? ub - 2*half : ub;
            case (op)
                4'd0:  r = (ua == ub) ? mask : 0;
                4'd1:  r = (sa > sb) ? mask : 0;
                4'd2:  r = (ua > ub) ? mask : 0;
                4'd3:  r = (sa < sb) ? ua : ub;
                4'd4:  r = (ua < ub) ? ua : ub;
                4'd5:  r = (sa > sb) ? ua : ub;
                4'd6:  r = (ua > ub) ? ua : ub;
                4'd7:  r = ua + ub;
                4'd8:  r = ua - ub;
                4'd9:  r = (ua + ub > mask) ? mask : ua + ub;
                4'd10: r = (ua >= ub) ? ua - ub : 0;
                4'd11, 4'd12: begin
                    s = (op == 4'd11) ? sa + sb : sa - sb;
                    if (s > half - 1) s = half - 1;
                    if (s < -half)    s = -half;
                    r = s;
                end
                4'd13: r = (ua + ub) >> 1;
                4'd14: r = (ua + ub + 1) >> 1;
                default: r = 0;
            endcase
            out |= (64'(r) & 64'(mask)) << (k*w);
        end
        return out;
    endfunction

    function automatic logic [31:0] ref_flags(input logic [63:0] r, input logic [1:0] sz,
                                              input logic [3:0] op);
        logic [31:0] f;
        logic [63:0] lane, mask;
        int w;
        w    = wid(sz);
        mask = (64'd1 << w) - 1;
        f    = '0;
        for (int k = 0; k < 64 / w; k++) begin
            lane = (r >> (k*w)) & mask;
            if (op != 4'd13 && op != 4'd14) f[k*(w/2) + w/2 - 1] = lane[w-1];
            f[k*(w/2) + w/2 - 2] = (lane == 0);
        end
        return f;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Issue one request, then check outputs and that they hold afterwards.
    task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                          input logic [1:0] sz, input logic [3:0] op, input string tag);
        logic [63:0] er;
        logic [31:0] ef;
        er = ref_res(a, b, sz, op);
        ef = ref_flags(er, sz, op);
        @(negedge clk);
        opnd_a = a; opnd_b = b; lane_sz = sz; op_sel = op; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R9 out_valid"}, 64'(out_valid), 64'd1);
        check({tag, " result"}, result, er);
        check({tag, " R7 flags"}, 64'(flags), 64'(ef));
        opnd_a = ~a; opnd_b = {$urandom, $urandom}; op_sel = 4'($urandom);
        @(negedge clk);
        check("R10 hold result", result, er);
        check("R10 hold flags", 64'(flags), 64'(ef));
        check("R9 out_valid low", 64'(out_valid), 64'd0);
    endtask

    function automatic logic [63:0] biased();
        logic [63:0] v;
        v = {$urandom, $urandom};
        for (int k = 0; k < 8; k++) begin
            case ($urandom % 6)
                0: v[k*8 +: 8] = 8'h00;
                1: v[k*8 +: 8] = 8'h7F;
                2: v[k*8 +: 8] = 8'h80;
                3: v[k*8 +: 8] = 8'hFF;
                default: ;
            endcase
        end
        return v;
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R10 reset out_valid", 64'(out_valid), 64'd0);
        check("R10 reset result", result, 64'd0);
        check("R10 reset flags", 64'(flags), 64'd0);
        rst_n = 1'b1;

        run_op(64'h1122_3344_5566_7788, 64'h1122_0044_5566_0088, 2'd0, 4'd0, "R1 cmpeq byte");
        run_op(64'h8000_7FFF_0001_FFFF, 64'h0001_8000_0001_0000, 2'd1, 4'd1, "R1 cmpgts half");
        run_op(64'h8000_7FFF_0001_FFFF, 64'h0001_8000_0001_0000, 2'd1, 4'd2, "R1 cmpgtu half");
        run_op(64'h80FF_017F_0000_0001, 64'h7F00_FF80_0000_00FF, 2'd0, 4'd3, "R2 mins byte");
        run_op(64'h80FF_017F_0000_0001, 64'h7F00_FF80_0000_00FF, 2'd0, 4'd6, "R2 maxu byte");
        run_op(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 2'd2, 4'd7, "R3 add wrap word");
        run_op(64'h0000_0000_0000_0005, 64'h0000_0001_0000_0006, 2'd3, 4'd8, "R6 R3 sub code3 word");
        run_op(64'h7F80_FF00_7F80_FF00, 64'h01FF_0101_0101_0101, 2'd0, 4'd11, "R4 addss byte");
        run_op(64'h7F80_FF00_7F80_FF00, 64'h01FF_0101_FF01_0101, 2'd0, 4'd12, "R4 subss byte");
        run_op(64'hFFFF_0000_8000_1234, 64'h0001_0001_8000_0001, 2'd1, 4'd9, "R4 addus half");
        run_op(64'hFFFF_0000_8000_1234, 64'h0001_0001_8000_0001, 2'd1, 4'd10, "R4 subus half");
        run_op(64'h7FFF_FFFF_8000_0000, 64'h0000_0001_0000_0001, 2'd2, 4'd11, "R4 addss word");
        run_op(64'h7FFF_FFFF_8000_0000, 64'hFFFF_FFFF_0000_0001, 2'd2, 4'd12, "R4 subss word");
        run_op(64'h01FF_0000_0100_FF01, 64'h02FF_0000_0000_FF00, 2'd0, 4'd13, "R5 R8 avg byte");
        run_op(64'h01FF_0000_0100_FF01, 64'h02FF_0000_0000_FF00, 2'd0, 4'd14, "R5 R8 avgr byte");
        run_op(64'hFFFF_0001_0000_8000, 64'hFFFF_0000_0000_8001, 2'd1, 4'd14, "R5 avgr half");
        run_op(64'hDEAD_BEEF_0123_4567, 64'h89AB_CDEF_FFFF_0000, 2'd1, 4'd15, "R11 reserved");

        for (int i = 0; i < 400; i++) begin
            logic [63:0] a, b;
            a = biased();
            b = ($urandom % 4 == 0) ? a : biased();
            run_op(a, b, 2'($urandom), 4'($urandom), "R1 R2 R3 R4 R5 R6 random");
        end

        // Back-to-back requests: R9 one result per cycle
        @(negedge clk);
        opnd_a = 64'h0102_0304_0506_0708; opnd_b = 64'h0101_0101_0101_0101;
        lane_sz = 2'd0; op_sel = 4'd7; in_valid = 1'b1;
        @(negedge clk);
        check("R9 b2b first", result, 64'h0203_0405_0607_0809);
        op_sel = 4'd8;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 b2b second", result, 64'h0001_0203_0405_0607);
        check("R9 b2b valid", 64'(out_valid), 64'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog: got no completion expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule